// File: doc/BRIEF.md
# Software Interrupt Flag Registers

This block holds two byte-wide registers through which software raises interrupts on a local processor. The first is a status/enable register. Its upper nibble holds four enable bits that software can read and write. Its lower nibble holds four flags that software can only read: two "message" flags and two "signal" flags. The second register is a strobe register that software can only write. Each of its bits, when written as 1, sets or clears one flag. A flag is never written directly.

Two requesters share the block: a local processor port and an external-bus port. Each port has address, write data, write enable, read enable and its own registered read data. When both ports write in the same cycle, the block merges the writes. Two registered, level-sensitive interrupt outputs come from the flags that are enabled. Each output stays high until its flag is cleared or its enable is dropped.

Top module: `swirq_regs`

## Requirements
- R1: After reset, every enable bit and every flag is 0, both interrupt outputs are 0, and both read-data outputs are 0.
- R2: The status register is at address 0x1001. In a write there, data bits 7..4 load the enables {sig1_en, sig0_en, msg1_en, msg0_en}, and bits 3..0 are ignored. A read of it returns {sig1_en, sig0_en, msg1_en, msg0_en, sig1, sig0, msg1, msg0}, from bit 7 down to bit 0.
- R3: The strobe register is at address 0x1000. Writing 1 to bit 7, 6, 5 or 4 sets sig1, sig0, msg1 or msg0 respectively.
- R4: Writing 1 to strobe bit 3, 2, 1 or 0 clears sig1, sig0, msg1 or msg0 respectively.
- R5: A strobe bit written as 0 leaves its flag unchanged.
- R6: When a set and a clear reach the same flag in the same cycle, the flag ends up set.
- R7: irq1 is high exactly when (sig1_en and sig1) or (msg1_en and msg1). irq0 is high exactly when (sig0_en and sig0) or (msg0_en and msg0). Both outputs change on the same clock edge as the register state.
- R8: A read of the strobe register, or of any other address, returns 0. A write to any address other than 0x1000 or 0x1001 changes nothing.
- R9: When both ports write the strobe register in the same cycle, their set bits are ORed together and their clear bits are ORed together.
- R10: When both ports write the status register in the same cycle, the local port's enable bits are loaded. When only the external port writes it, the external port's bits are loaded.
- R11: Read data is registered. It is loaded on the clock edge where that port's read enable is high, with the register contents from before any write on that same edge. It holds its value while read enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_addr | input | 16 | Local port address |
| loc_wdata | input | 8 | Local port write data |
| loc_we | input | 1 | Local port write enable |
| loc_re | input | 1 | Local port read enable |
| loc_rdata | output | 8 | Local port registered read data |
| ext_addr | input | 16 | External port address |
| ext_wdata | input | 8 | External port write data |
| ext_we | input | 1 | External port write enable |
| ext_re | input | 1 | External port read enable |
| ext_rdata | output | 8 | External port registered read data |
| irq0 | output | 1 | Interrupt line 0, level |
| irq1 | output | 1 | Interrupt line 1, level |

## Verification
The assertions assume only that the write enables, read enables and addresses are known (not X) on each clock edge while reset is released. Beyond that they accept any input, including both ports hitting the same register at once. The stimulus drives every input to a defined value from time zero, and returns the enables to 0 between accesses. The sweeps cover every enable/flag combination, every strobe byte applied to every starting flag pattern, and the merge of two ports writing at once.

// File: rtl/swirq_regs.sv
module swirq_regs #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter logic [15:0] STAT_ADDR = 16'h1001,
  parameter logic [15:0] STRB_ADDR = 16'h1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic [DATA_W-1:0] loc_wdata,
  input  logic              loc_we,
  input  logic              loc_re,
  output logic [DATA_W-1:0] loc_rdata,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic [DATA_W-1:0] ext_wdata,
  input  logic              ext_we,
  input  logic              ext_re,
  output logic [DATA_W-1:0] ext_rdata,
  output logic              irq0,
  output logic              irq1
);
  localparam int NF = DATA_W / 2;

  logic [NF-1:0] en_q, fl_q, en_d, fl_d;
  logic [NF-1:0] set_v, clr_v;
  logic          loc_st_wr, loc_sb_wr, ext_st_wr, ext_sb_wr;
  logic [DATA_W-1:0] stat_word;

  assign loc_st_wr = loc_we && (loc_addr == STAT_ADDR[ADDR_W-1:0]);
  assign loc_sb_wr = loc_we && (loc_addr == STRB_ADDR[ADDR_W-1:0]);
  assign ext_st_wr = ext_we && (ext_addr == STAT_ADDR[ADDR_W-1:0]);
  assign ext_sb_wr = ext_we && (ext_addr == STRB_ADDR[ADDR_W-1:0]);

  assign set_v = (loc_sb_wr ? loc_wdata[DATA_W-1:NF] : '0)
               | (ext_sb_wr ? ext_wdata[DATA_W-1:NF] : '0);
  assign clr_v = (loc_sb_wr ? loc_wdata[NF-1:0] : '0)
               | (ext_sb_wr ? ext_wdata[NF-1:0] : '0);

  assign fl_d = (fl_q & ~clr_v) | set_v;
  assign en_d = loc_st_wr ? loc_wdata[DATA_W-1:NF]
              : ext_st_wr ? ext_wdata[DATA_W-1:NF]
              : en_q;

  assign stat_word = {en_q, fl_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
      fl_q <= '0;
      irq0 <= 1'b0;
      irq1 <= 1'b0;
    end else begin
      en_q <= en_d;
      fl_q <= fl_d;
      irq1 <= (en_d[3] & fl_d[3]) | (en_d[1] & fl_d[1]);
      irq0 <= (en_d[2] & fl_d[2]) | (en_d[0] & fl_d[0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loc_rdata <= '0;
      ext_rdata <= '0;
    end else begin
      if (loc_re)
        loc_rdata <= (loc_addr == STAT_ADDR[ADDR_W-1:0]) ? stat_word : '0;
      if (ext_re)
        ext_rdata <= (ext_addr == STAT_ADDR[ADDR_W-1:0]) ? stat_word : '0;
    end
  end
endmodule

module swirq_regs_chk #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter logic [15:0] STAT_ADDR = 16'h1001,
  parameter logic [15:0] STRB_ADDR = 16'h1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] loc_addr,
  input logic [DATA_W-1:0] loc_wdata,
  input logic              loc_we,
  input logic              loc_re,
  input logic [DATA_W-1:0] loc_rdata,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [DATA_W-1:0] ext_wdata,
  input logic              ext_we,
  input logic              ext_re,
  input logic              irq0,
  input logic              irq1,
  input logic [3:0]        en_q,
  input logic [3:0]        fl_q
);
  logic loc_sb, ext_sb, loc_st, ext_st;
  assign loc_sb = loc_we && loc_addr == STRB_ADDR[ADDR_W-1:0];
  assign ext_sb = ext_we && ext_addr == STRB_ADDR[ADDR_W-1:0];
  assign loc_st = loc_we && loc_addr == STAT_ADDR[ADDR_W-1:0];
  assign ext_st = ext_we && ext_addr == STAT_ADDR[ADDR_W-1:0];

  p_flags_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!loc_sb && !ext_sb) |=> $stable(fl_q));

  p_set_msg0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_sb && loc_wdata[4]) |=> fl_q[0]);

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_sb && loc_wdata[7] && ext_sb && ext_wdata[3]) |=> fl_q[3]);

  p_clear_sig0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sb && ext_wdata[2] && !(loc_sb && loc_wdata[6]) && !ext_wdata[6]) |=> !fl_q[2]);

  p_irq_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq1 == ((en_q[3] & fl_q[3]) | (en_q[1] & fl_q[1]))) &&
    (irq0 == ((en_q[2] & fl_q[2]) | (en_q[0] & fl_q[0]))));

  p_local_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_st && ext_st) |=> en_q == $past(loc_wdata[7:4]));

  p_en_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!loc_st && !ext_st) |=> $stable(en_q));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !loc_re |=> $stable(loc_rdata));
endmodule

bind swirq_regs swirq_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_ADDR(STAT_ADDR), .STRB_ADDR(STRB_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .loc_addr(loc_addr), .loc_wdata(loc_wdata), .loc_we(loc_we), .loc_re(loc_re),
  .loc_rdata(loc_rdata),
  .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_we(ext_we), .ext_re(ext_re),
  .irq0(irq0), .irq1(irq1), .en_q(en_q), .fl_q(fl_q)
);

// File: tb/swirq_regs_tb.sv
module swirq_regs_tb_top;
  localparam logic [15:0] ST = 16'h1001;
  localparam logic [15:0] SB = 16'h1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] loc_addr = '0, ext_addr = '0;
  logic [7:0]  loc_wdata = '0, ext_wdata = '0;
  logic        loc_we = 1'b0, loc_re = 1'b0, ext_we = 1'b0, ext_re = 1'b0;
  logic [7:0]  loc_rdata, ext_rdata;
  logic        irq0, irq1;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [3:0] en_m = '0, fl_m = '0;
  logic [7:0] lrd_m = '0, xrd_m = '0;

  always #2.5 clk = ~clk;

  swirq_regs dut_i (
    .clk(clk), .rst_n(rst_n),
    .loc_addr(loc_addr), .loc_wdata(loc_wdata), .loc_we(loc_we), .loc_re(loc_re),
    .loc_rdata(loc_rdata),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_we(ext_we), .ext_re(ext_re),
    .ext_rdata(ext_rdata), .irq0(irq0), .irq1(irq1)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit lwe, input bit lre, input logic [15:0] la, input logic [7:0] lw,
                     input bit xwe, input bit xre, input logic [15:0] xa, input logic [7:0] xw);
    logic [3:0] s, c;
    loc_we = lwe; loc_re = lre; loc_addr = la; loc_wdata = lw;
    ext_we = xwe; ext_re = xre; ext_addr = xa; ext_wdata = xw;
    @(posedge clk);
    if (lre) lrd_m = (la == ST) ? {en_m, fl_m} : 8'h00;
    if (xre) xrd_m = (xa == ST) ? {en_m, fl_m} : 8'h00;
    s = '0; c = '0;
    if (lwe && la == SB) begin s |= lw[7:4]; c |= lw[3:0]; end
    if (xwe && xa == SB) begin s |= xw[7:4]; c |= xw[3:0]; end
    fl_m = (fl_m & ~c) | s;
    if (lwe && la == ST) en_m = lw[7:4];
    else if (xwe && xa == ST) en_m = xw[7:4];
    @(negedge clk);
    loc_we = 0; loc_re = 0; ext_we = 0; ext_re = 0;
  endtask

  task automatic lwr(input logic [15:0] a, input logic [7:0] d);
    cyc(1, 0, a, d, 0, 0, 16'h0, 8'h0);
  endtask

  task automatic xwr(input logic [15:0] a, input logic [7:0] d);
    cyc(0, 0, 16'h0, 8'h0, 1, 0, a, d);
  endtask

  task automatic rd_both(input logic [15:0] a, input string req);
    cyc(0, 1, a, 8'h0, 0, 1, a, 8'h0);
    chk(loc_rdata == lrd_m, req, loc_rdata, lrd_m);
    chk(ext_rdata == xrd_m, req, ext_rdata, xrd_m);
  endtask

  task automatic chk_irq(input string req);
    logic e1, e0;
    e1 = (en_m[3] & fl_m[3]) | (en_m[1] & fl_m[1]);
    e0 = (en_m[2] & fl_m[2]) | (en_m[0] & fl_m[0]);
    chk({irq1, irq0} == {e1, e0}, req, {irq1, irq0}, {e1, e0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({irq1, irq0, loc_rdata, ext_rdata} == 18'h0, "R1 reset outputs",
        {irq1, irq0, loc_rdata, ext_rdata}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_both(ST, "R1 reset status");

    // R2 / R7: every enable pattern against every flag pattern
    for (int e = 0; e < 16; e++) begin
      for (int f = 0; f < 16; f++) begin
        lwr(SB, {f[3:0], 4'hF});
        xwr(ST, {e[3:0], ~f[3:0]});
        chk_irq("R7 irq levels");
        rd_both(ST, "R2 status readback");
      end
    end

    // R3 / R4 / R5 / R6: every strobe byte on every starting flag pattern
    for (int f = 0; f < 16; f++) begin
      for (int c = 0; c < 256; c++) begin
        lwr(SB, {f[3:0], 4'hF});
        xwr(SB, c[7:0]);
        cyc(0, 1, ST, 8'h0, 0, 0, 16'h0, 8'h0);
        chk(loc_rdata == lrd_m,
            ((c[7:4] & c[3:0]) != 0) ? "R6 set beats clear" : "R3 R4 R5 strobe result",
            loc_rdata, lrd_m);
      end
    end

    // R8: strobe reads zero, foreign addresses inert
    lwr(ST, 8'hA0);
    lwr(SB, 8'h50);
    rd_both(SB, "R8 strobe reads zero");
    lwr(16'h1002, 8'hFF);
    xwr(16'h0001, 8'h0F);
    lwr(16'h1003, 8'hF0);
    rd_both(ST, "R8 foreign write ignored");
    rd_both(16'h2001, "R8 foreign read zero");
    chk_irq("R8 irq unchanged");

    // R9: simultaneous strobe writes merge
    for (int l = 0; l < 16; l++) begin
      for (int x = 0; x < 16; x++) begin
        lwr(SB, 8'h0F);
        cyc(1, 0, SB, {l[3:0], 4'h0}, 1, 0, SB, {x[3:0], 4'h0});
        rd_both(ST, "R9 merged sets");
        cyc(1, 0, SB, {4'h0, l[3:0]}, 1, 0, SB, {4'h0, x[3:0]});
        rd_both(ST, "R9 merged clears");
      end
    end

    // R10: status write priority
    for (int l = 0; l < 16; l++) begin
      cyc(1, 0, ST, {l[3:0], 4'h0}, 1, 0, ST, {~l[3:0], 4'h0});
      rd_both(ST, "R10 local priority");
      xwr(ST, {l[3:0] ^ 4'h5, 4'h0});
      rd_both(ST, "R10 external alone");
    end

    // R11: read-during-write returns prior value, hold when idle
    lwr(SB, 8'h0F);
    lwr(ST, 8'h00);
    cyc(1, 1, ST, 8'hF0, 0, 1, ST, 8'h0);
    chk(loc_rdata == 8'h00, "R11 read before write", loc_rdata, 8'h00);
    cyc(0, 0, 16'h0, 8'h0, 1, 0, SB, 8'hC0);
    chk(loc_rdata == 8'h00 && ext_rdata == 8'h00, "R11 rdata hold", {loc_rdata, ext_rdata}, 0);
    rd_both(ST, "R11 fresh read");
    chk(loc_rdata == 8'hFC, "R11 expected word", loc_rdata, 8'hFC);
    chk_irq("R7 final irq");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule